// File: doc/BRIEF.md
# Strip Edge Traversal Sequencer

This block walks one band of triangles lying between two neighbouring rings of a concentric mesh group and issues, one per clock, the vertex index pairs of the edges that later stages must evaluate. It reads three small register files that the caller holds stable for the whole walk. The first holds the inner ring's root vertex indices. The second holds the outer ring's child vertex indices. The third holds, for every root, how many outer-ring vertices that root is connected to.

Neighbouring roots share one boundary child: the last child of a root is also the first child of the next root. The sequencer therefore derives each root's first child position from the previous root's position and count. For each root it issues the edge to its first child. For each further child it issues the root-to-child edge and then the edge joining the previous child to that child. A closed-ring flag makes the last root's last child fold back onto the first child of the ring. Edges leave on a valid/ready stream. A one-cycle done pulse follows the last accepted edge.

Top module: `strip_edge_seq`

## Requirements
- R1: After reset, edge_valid_o and done_o are low until a walk is started.
- R2: For a root with count n of at least 1, the edges are issued in this order. First comes (root, child at offset 0). Then, for each offset i from 1 to n-1, come (root, child i) and then (child i-1, child i). edge_a_o carries the first vertex of the pair and edge_b_o the second.
- R3: The first counted root starts at child position 0. Each later counted root starts at the previous start plus the previous count minus one, so its first child is the previous root's last child.
- R4: A root whose count is 1 issues exactly one edge, from the root to its single child.
- R5: A root whose count is 0 issues no edge and leaves the child start position unchanged. A row with no counted roots, or num_roots_i of 0, issues no edge.
- R6: When closed_i is 1, the last child of the last counted root is taken from child position 0. When closed_i is 0, it is taken from its computed position.
- R7: With edge_ready_i held high, one edge is issued per cycle from the cycle after start_i is sampled until the last edge, with no idle cycle in between.
- R8: While edge_valid_o is high and edge_ready_i is low, the edge held on edge_a_o and edge_b_o stays unchanged, and no edge is lost.
- R9: done_o is high for one cycle, in the cycle after the last edge is accepted, with edge_valid_o low. For an empty row, it is high in the cycle after start_i is sampled.
- R10: start_i is ignored while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk of the presented row (sampled when idle) |
| num_roots_i | input | $clog2(N_ROOT+1) | Number of roots in the inner ring |
| closed_i | input | 1 | Ring closes back onto child position 0 |
| root_idx_i | input | N_ROOT*IDX_W | Root vertex indices, entry j at bits j*IDX_W |
| child_idx_i | input | N_CHILD*IDX_W | Child vertex indices, entry j at bits j*IDX_W |
| child_cnt_i | input | N_ROOT*CNT_W | Per-root connected child count, entry j at bits j*CNT_W |
| edge_valid_o | output | 1 | Edge on edge_a_o/edge_b_o is valid |
| edge_ready_i | input | 1 | Consumer accepts the edge |
| edge_a_o | output | IDX_W | First vertex of the edge |
| edge_b_o | output | IDX_W | Second vertex of the edge |
| done_o | output | 1 | One-cycle pulse ending a walk |

## Verification
Four row shapes are used. A mixed-count open row separates correct shared-child stepping from independent child ranges. A row with zero and single counts shows whether skipped roots disturb the start position, and whether a single child still yields exactly one edge. A closed ring separates folding the last child onto position 0 from walking past the end of the row. Two further cases cover an empty row, which should produce only done, and the mixed row replayed under a periodic ready stall with a start pulse arriving mid-walk, which exposes dropped or duplicated edges and spurious restarts.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;
  typedef enum logic {
    PH_ROOT = 1'b0,  // root to current child
    PH_PAIR = 1'b1   // previous child to current child
  } phase_e;
endpackage

// File: rtl/strip_idx_sel.sv
module strip_idx_sel #(
  parameter int N     = 8,
  parameter int W     = 8,
  parameter int PTR_W = 4
) (
  input  logic [N*W-1:0] flat_i,
  input  logic [PTR_W-1:0] pos_i,
  output logic [W-1:0]   val_o
);
  always_comb begin
    val_o = '0;
    for (int j = 0; j < N; j++) begin
      if (pos_i == PTR_W'(j)) val_o = flat_i[j*W +: W];
    end
  end
endmodule

// File: rtl/strip_next_root.sv
module strip_next_root #(
  parameter int N_ROOT = 8,
  parameter int CNT_W  = 4,
  parameter int RPTR_W = 4
) (
  input  logic [N_ROOT*CNT_W-1:0] cnt_flat_i,
  input  logic [RPTR_W-1:0]       num_roots_i,
  input  logic [RPTR_W-1:0]       from_i,
  output logic [RPTR_W-1:0]       idx_o     // num_roots_i when none left
);
  always_comb begin
    idx_o = num_roots_i;
    for (int j = N_ROOT - 1; j >= 0; j--) begin
      if (RPTR_W'(j) >= from_i && RPTR_W'(j) < num_roots_i &&
          cnt_flat_i[j*CNT_W +: CNT_W] != '0)
        idx_o = RPTR_W'(j);
    end
  end
endmodule

// File: rtl/strip_edge_seq.sv
module strip_edge_seq
  import strip_seq_pkg::*;
#(
  parameter int N_ROOT  = 8,
  parameter int N_CHILD = 16,
  parameter int IDX_W   = 8,
  parameter int CNT_W   = 4,
  localparam int RPTR_W = $clog2(N_ROOT + 1),
  localparam int CPTR_W = $clog2(N_CHILD + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [RPTR_W-1:0]        num_roots_i,
  input  logic                     closed_i,
  input  logic [N_ROOT*IDX_W-1:0]  root_idx_i,
  input  logic [N_CHILD*IDX_W-1:0] child_idx_i,
  input  logic [N_ROOT*CNT_W-1:0]  child_cnt_i,
  output logic                     edge_valid_o,
  input  logic                     edge_ready_i,
  output logic [IDX_W-1:0]         edge_a_o,
  output logic [IDX_W-1:0]         edge_b_o,
  output logic                     done_o
);
  logic              active_q, done_q;
  logic [RPTR_W-1:0] k_q;
  logic [CPTR_W-1:0] s_q;
  logic [CNT_W-1:0]  i_q;
  phase_e            ph_q;

  logic [RPTR_W-1:0] first_root, next_root, k_plus1;
  logic [CNT_W-1:0]  cur_cnt, cnt_m1;
  logic [IDX_W-1:0]  root_idx, cur_child, prev_child;
  logic [CPTR_W-1:0] raw_pos, cur_pos, prev_pos;
  logic              last_root, last_child, fire;

  assign k_plus1 = RPTR_W'(k_q + 1'b1);

  strip_next_root #(.N_ROOT(N_ROOT), .CNT_W(CNT_W), .RPTR_W(RPTR_W)) u_scan_first (
    .cnt_flat_i(child_cnt_i), .num_roots_i(num_roots_i),
    .from_i('0), .idx_o(first_root));

  strip_next_root #(.N_ROOT(N_ROOT), .CNT_W(CNT_W), .RPTR_W(RPTR_W)) u_scan_next (
    .cnt_flat_i(child_cnt_i), .num_roots_i(num_roots_i),
    .from_i(k_plus1), .idx_o(next_root));

  strip_idx_sel #(.N(N_ROOT), .W(CNT_W), .PTR_W(RPTR_W)) u_sel_cnt (
    .flat_i(child_cnt_i), .pos_i(k_q), .val_o(cur_cnt));

  strip_idx_sel #(.N(N_ROOT), .W(IDX_W), .PTR_W(RPTR_W)) u_sel_root (
    .flat_i(root_idx_i), .pos_i(k_q), .val_o(root_idx));

  assign cnt_m1     = CNT_W'(cur_cnt - 1'b1);
  assign last_root  = (next_root == num_roots_i);
  assign last_child = (i_q == cnt_m1);
  assign raw_pos    = CPTR_W'(s_q + CPTR_W'(i_q));
  assign cur_pos    = (closed_i && last_root && last_child) ? '0 : raw_pos;
  assign prev_pos   = CPTR_W'(raw_pos - 1'b1);

  strip_idx_sel #(.N(N_CHILD), .W(IDX_W), .PTR_W(CPTR_W)) u_sel_cur (
    .flat_i(child_idx_i), .pos_i(cur_pos), .val_o(cur_child));

  strip_idx_sel #(.N(N_CHILD), .W(IDX_W), .PTR_W(CPTR_W)) u_sel_prev (
    .flat_i(child_idx_i), .pos_i(prev_pos), .val_o(prev_child));

  assign edge_valid_o = active_q;
  assign edge_a_o     = (ph_q == PH_ROOT) ? root_idx : prev_child;
  assign edge_b_o     = cur_child;
  assign done_o       = done_q;
  assign fire         = active_q && edge_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      k_q      <= '0;
      s_q      <= '0;
      i_q      <= '0;
      ph_q     <= PH_ROOT;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          if (first_root == num_roots_i) begin
            done_q <= 1'b1;
          end else begin
            active_q <= 1'b1;
            k_q      <= first_root;
            s_q      <= '0;
            i_q      <= '0;
            ph_q     <= PH_ROOT;
          end
        end
      end else if (fire) begin
        if (ph_q == PH_ROOT && i_q != '0) begin
          ph_q <= PH_PAIR;
        end else if (last_child) begin
          i_q  <= '0;
          ph_q <= PH_ROOT;
          s_q  <= CPTR_W'(s_q + CPTR_W'(cnt_m1));  // shared boundary child
          if (last_root) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            k_q <= next_root;
          end
        end else begin
          i_q  <= CNT_W'(i_q + 1'b1);
          ph_q <= PH_ROOT;
        end
      end
    end
  end

  a_r8_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_valid_o && !edge_ready_i |=> edge_valid_o && $stable(edge_a_o) && $stable(edge_b_o));

  a_r9_done_not_with_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !edge_valid_o);

  a_r9_done_ends_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(edge_valid_o) |-> done_o);

  a_r2_pair_keeps_child: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && ph_q == PH_ROOT && i_q != '0 |=> edge_b_o == $past(edge_b_o));

  a_r5_no_empty_root: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_valid_o |-> cur_cnt != '0);

endmodule

// File: tb/strip_edge_seq_test.sv
`timescale 1ns/1ps
module strip_edge_seq_test;
  localparam int N_ROOT = 8, N_CHILD = 16, IDX_W = 8, CNT_W = 4;
  localparam int RPTR_W = $clog2(N_ROOT + 1);

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, closed_i = 1'b0, edge_ready_i = 1'b0;
  logic [RPTR_W-1:0] num_roots_i = '0;
  logic [N_ROOT*IDX_W-1:0]  root_idx_i = '0;
  logic [N_CHILD*IDX_W-1:0] child_idx_i = '0;
  logic [N_ROOT*CNT_W-1:0]  child_cnt_i = '0;
  logic edge_valid_o, done_o;
  logic [IDX_W-1:0] edge_a_o, edge_b_o;

  int n_tests = 0, n_fail = 0;
  int r_arr[N_ROOT], c_arr[N_CHILD], n_arr[N_ROOT];
  int nr;
  bit cl;
  int exp_a[64], exp_b[64];
  int exp_n;

  always #10 clk = ~clk;

  strip_edge_seq #(.N_ROOT(N_ROOT), .N_CHILD(N_CHILD), .IDX_W(IDX_W), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .num_roots_i(num_roots_i),
    .closed_i(closed_i), .root_idx_i(root_idx_i), .child_idx_i(child_idx_i),
    .child_cnt_i(child_cnt_i), .edge_valid_o(edge_valid_o), .edge_ready_i(edge_ready_i),
    .edge_a_o(edge_a_o), .edge_b_o(edge_b_o), .done_o(done_o));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_row();
    for (int j = 0; j < N_ROOT; j++) begin
      root_idx_i[j*IDX_W +: IDX_W] = IDX_W'(r_arr[j]);
      child_cnt_i[j*CNT_W +: CNT_W] = CNT_W'(n_arr[j]);
    end
    for (int j = 0; j < N_CHILD; j++) child_idx_i[j*IDX_W +: IDX_W] = IDX_W'(c_arr[j]);
    num_roots_i = RPTR_W'(nr);
    closed_i = cl;
  endtask

  // Expected edge list from R2..R6
  task automatic build_exp();
    int s, last, pos;
    s = 0; last = -1; exp_n = 0;
    for (int k = 0; k < nr; k++) if (n_arr[k] != 0) last = k;
    for (int k = 0; k < nr; k++) begin
      if (n_arr[k] == 0) continue;
      for (int i = 0; i < n_arr[k]; i++) begin
        pos = s + i;
        if (cl && k == last && i == n_arr[k] - 1) pos = 0;
        exp_a[exp_n] = r_arr[k]; exp_b[exp_n] = c_arr[pos]; exp_n++;
        if (i > 0) begin
          exp_a[exp_n] = c_arr[s + i - 1]; exp_b[exp_n] = c_arr[pos]; exp_n++;
        end
      end
      s = s + n_arr[k] - 1;
    end
  endtask

  task automatic run_strip(input string req, input bit stall, input bit poke);
    int got, gaps, cyc;
    bit done_seen;
    load_row();
    build_exp();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    got = 0; gaps = 0; cyc = 0; done_seen = 0;
    while (!done_seen && cyc < 300) begin
      edge_ready_i = stall ? (cyc % 3 != 1) : 1'b1;
      start_i = poke && (cyc == 2);   // R10: restart attempt mid-walk
      if (done_o) begin
        done_seen = 1;
        check(!edge_valid_o, "R9", "valid with done", int'(edge_valid_o), 0);
      end else if (!edge_valid_o) gaps++;
      if (edge_valid_o && edge_ready_i) begin
        if (got < exp_n) begin
          check(int'(edge_a_o) == exp_a[got], req, $sformatf("edge %0d vertex A", got), int'(edge_a_o), exp_a[got]);
          check(int'(edge_b_o) == exp_b[got], req, $sformatf("edge %0d vertex B", got), int'(edge_b_o), exp_b[got]);
        end
        got++;
      end
      @(negedge clk); cyc++;
    end
    start_i = 1'b0;
    edge_ready_i = 1'b0;
    check(done_seen, "R9", "done seen", int'(done_seen), 1);
    check(got == exp_n, stall ? "R8" : "R7", "edge count", got, exp_n);
    if (!stall) check(gaps == 0, "R7", "idle cycles inside walk", gaps, 0);
    check(!done_o, "R9", "done width", int'(done_o), 0);
    check(!edge_valid_o, "R10", "valid after walk", int'(edge_valid_o), 0);
  endtask

  task automatic clear_row();
    for (int j = 0; j < N_ROOT; j++) begin r_arr[j] = 10 + j; n_arr[j] = 0; end
    for (int j = 0; j < N_CHILD; j++) c_arr[j] = 100 + j;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!edge_valid_o, "R1", "valid after reset", int'(edge_valid_o), 0);
    check(!done_o, "R1", "done after reset", int'(done_o), 0);
  endtask

  task automatic t_open_mixed(input bit stall, input bit poke);
    clear_row();
    nr = 4; cl = 0;
    n_arr[0] = 5; n_arr[1] = 3; n_arr[2] = 1; n_arr[3] = 3;
    run_strip(stall ? "R8/R10" : "R2/R3/R4", stall, poke);
  endtask

  task automatic t_skips();
    clear_row();
    nr = 6; cl = 0;
    n_arr[0] = 0; n_arr[1] = 2; n_arr[2] = 0; n_arr[3] = 1; n_arr[4] = 3; n_arr[5] = 0;
    run_strip("R5/R4/R3", 1'b0, 1'b0);
  endtask

  task automatic t_closed();
    clear_row();
    nr = 3; cl = 1;
    n_arr[0] = 3; n_arr[1] = 2; n_arr[2] = 3;
    run_strip("R6", 1'b0, 1'b0);
    cl = 0;
    run_strip("R6", 1'b0, 1'b0);
  endtask

  task automatic t_empty();
    clear_row();
    nr = 0; cl = 0;
    run_strip("R5/R9", 1'b0, 1'b0);
    nr = 5;
    run_strip("R5/R9", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_open_mixed(1'b0, 1'b0);
    t_open_mixed(1'b1, 1'b1);
    t_skips();
    t_closed();
    t_empty();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule